// File: doc/BRIEF.md
# Multiprocessor Level-Mapped Interrupt Controller

This block gathers 32 system interrupt source lines, translates each source into one of sixteen processor interrupt levels through a fixed, irregular mapping, and decides whether to raise an interrupt request. A single 32-bit register bus reaches one master page, which holds the system-wide pending, disable and target-processor state, and one small page per processor, which holds the levels currently pending for that processor. Several sources share a level, so software reads the master pending word to tell apart sources that share one.

A source edge records itself twice. It sets its bit in the master pending word, and it sets the bit of its level in the pending word of the processor currently named as target. The falling edge clears both. Each cycle the block finds the highest level that may be delivered, given the per-source and global disable bits and the processor's priority and trap-enable inputs. It presents that level, with an external-interrupt flag, on a registered request output. Register accesses complete in one cycle. Writes take effect at the clock edge and reads are combinational.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset every master disable bit reads 1, the master pending word, every processor pending word and the target field read 0, and no request is raised.
- R2: Source n maps to a level through the fixed table below, listed for n = 0..31: 2,3,5,7,9,11,0,14,3,5,7,9,11,13,12,12,6,0,4,10,8,0,11,0,0,0,0,0,15,0,0,0.
- R3: A rising edge on source n sets master pending bit n and sets bit L(n) in the target processor's pending word at the next clock edge. A falling edge clears both bits at the next clock edge.
- R4: Source n qualifies for delivery only while its master pending bit is 1, its disable bit is 0, disable bit 31 (global) is 0, and either L(n) is 15, or L(n) is strictly greater than the priority input while trap-enable is 1.
- R5: One cycle after the qualifying set is formed, the request output shows the external flag at 1 and the highest qualifying level. When nothing qualifies, the flag is 0 and the level is 0.
- R6: A master write at word offset 2 clears each disable bit where the data bit is 1, which enables those sources.
- R7: A master write at word offset 3 sets each disable bit where the data bit is 1, and clears the matching master pending bits.
- R8: A master write at word offset 4 loads the target as the data ANDed with NCPU-1. Later source edges update the pending word of the new target.
- R9: The master page is selected by address bit 15 = 1, with the word offset in bits 4:2. Reads at offset 0 return pending, at 1 return disable, at 4 return the target, and at any other offset return 0.
- R10: A processor page is selected by address bit 15 = 0, with the processor index in bits starting at bit 12 and the word offset in bits 3:2. A write at offset 1 clears pending bits where the data is 1, a write at offset 2 sets them, writes at offsets 0 and 3 have no effect, and a read at any offset returns that processor's pending word.
- R11: When a source edge and a register write touch the same pending bit in one cycle, the source edge wins.
- R12: An access with address bits 1:0 not zero, or with a non-zero bit outside the fields named in R9 and R10, is ignored on write and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| srcLines | input | 32 | System interrupt source lines |
| busAddr | input | ADDR_W (16) | Register byte address |
| busWe | input | 1 | Write enable for the current access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the current address |
| cpuPil | input | 4 | Current processor priority level |
| cpuTrapEn | input | 1 | Processor trap-enable |
| reqExt | output | 1 | External interrupt request flag |
| reqLevel | output | 4 | Level of the request, 0 when idle |

## Verification
Source edges and register writes can land in the same cycle and touch the same pending bit. One case is a disable-set write that clears master pending while that source rises. Another is a processor-page clear while a source of that level rises. The bench drives both stimuli in the same low clock phase and reads both registers back after the edge. It expects the pending bit set, the disable bit set, and no request raised.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

  localparam int SRC_N = 32;
  localparam int LVL_N = 16;
  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_MPEND,
    RD_MDIS,
    RD_TGT,
    RD_CPEND
  } rdSel_e;

  typedef struct packed {
    logic enWr;       // master offset 2
    logic disWr;      // master offset 3
    logic tgtWr;      // master offset 4
    logic pendClrWr;  // processor page offset 1
    logic pendSetWr;  // processor page offset 2
  } wrStrobe_t;

  function automatic logic [3:0] srcToLevel(input logic [4:0] idx);
    logic [3:0] lv;
    case (idx)
      5'd0:  lv = 4'd2;
      5'd1:  lv = 4'd3;
      5'd2:  lv = 4'd5;
      5'd3:  lv = 4'd7;
      5'd4:  lv = 4'd9;
      5'd5:  lv = 4'd11;
      5'd7:  lv = 4'd14;
      5'd8:  lv = 4'd3;
      5'd9:  lv = 4'd5;
      5'd10: lv = 4'd7;
      5'd11: lv = 4'd9;
      5'd12: lv = 4'd11;
      5'd13: lv = 4'd13;
      5'd14: lv = 4'd12;
      5'd15: lv = 4'd12;
      5'd16: lv = 4'd6;
      5'd18: lv = 4'd4;
      5'd19: lv = 4'd10;
      5'd20: lv = 4'd8;
      5'd22: lv = 4'd11;
      5'd28: lv = 4'd15;
      default: lv = 4'd0;
    endcase
    return lv;
  endfunction

endpackage

// File: rtl/lvl_irq_decode.sv
module lvl_irq_decode
  import lvl_irq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CPU_W = 2
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output wrStrobe_t         strb,
  output rdSel_e            rdSel,
  output logic [CPU_W-1:0]  pageIdx
);

  localparam int PAGE_LSB = 12;
  localparam int MOFF_W = 3;
  localparam int COFF_W = 2;

  logic alignOk;
  logic masterHit;
  logic cpuHit;
  logic [MOFF_W-1:0] mOff;
  logic [COFF_W-1:0] cOff;
  logic [ADDR_W-2:0] lowAddr;

  assign lowAddr = busAddr[ADDR_W-2:0];
  assign alignOk = (busAddr[1:0] == 2'b00);
  assign mOff = busAddr[4:2];
  assign cOff = busAddr[3:2];
  assign pageIdx = busAddr[PAGE_LSB +: CPU_W];

  // master page: top bit set, nothing between the top bit and bit 5
  assign masterHit = busAddr[ADDR_W-1] && alignOk && ((lowAddr >> 5) == '0);
  // processor page: top bit clear, index field only above bit 11, bits 11:4 zero
  assign cpuHit = !busAddr[ADDR_W-1] && alignOk &&
                  ((lowAddr >> (PAGE_LSB + CPU_W)) == '0) &&
                  (busAddr[11:4] == 8'h00);

  always_comb begin
    strb = '0;
    if (busWe && masterHit) begin
      strb.enWr  = (mOff == 3'd2);
      strb.disWr = (mOff == 3'd3);
      strb.tgtWr = (mOff == 3'd4);
    end
    if (busWe && cpuHit) begin
      strb.pendClrWr = (cOff == 2'd1);
      strb.pendSetWr = (cOff == 2'd2);
    end
  end

  always_comb begin
    rdSel = RD_ZERO;
    if (masterHit) begin
      case (mOff)
        3'd0: rdSel = RD_MPEND;
        3'd1: rdSel = RD_MDIS;
        3'd4: rdSel = RD_TGT;
        default: rdSel = RD_ZERO;
      endcase
    end else if (cpuHit) begin
      rdSel = RD_CPEND;
    end
  end

endmodule

// File: rtl/lvl_irq_datapath.sv
module lvl_irq_datapath
  import lvl_irq_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int CPU_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SRC_N-1:0]  srcLines,
  input  wrStrobe_t         strb,
  input  rdSel_e            rdSel,
  input  logic [CPU_W-1:0]  pageIdx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [3:0]        cpuPil,
  input  logic              cpuTrapEn,
  output logic [DATA_W-1:0] rdata,
  output logic              reqExt,
  output logic [3:0]        reqLevel
);

  localparam int GDIS_BIT = SRC_N - 1;

  logic [SRC_N-1:0]  srcPrev;
  logic [SRC_N-1:0]  srcRise;
  logic [SRC_N-1:0]  srcFall;
  logic [SRC_N-1:0]  pendM;
  logic [SRC_N-1:0]  disM;
  logic [CPU_W-1:0]  tgt;
  logic [DATA_W-1:0] pendC [NCPU];
  logic [DATA_W-1:0] pendCNext [NCPU];
  logic [LVL_N-1:0]  setLvl;
  logic [LVL_N-1:0]  clrLvl;
  logic [LVL_N-1:0]  qualLvl;
  logic [3:0]        bestLvl;
  logic              anyQual;
  logic [SRC_N-1:0]  disSetMask;
  logic [SRC_N-1:0]  enMask;

  assign srcRise = srcLines & ~srcPrev;
  assign srcFall = ~srcLines & srcPrev;
  assign disSetMask = strb.disWr ? wdata : '0;
  assign enMask = strb.enWr ? wdata : '0;

  // level masks from edges, and qualifying levels from state
  always_comb begin
    logic [3:0] lv;
    setLvl = '0;
    clrLvl = '0;
    qualLvl = '0;
    for (int n = 0; n < SRC_N; n++) begin
      lv = srcToLevel(5'(n));
      if (srcRise[n]) setLvl[lv] = 1'b1;
      if (srcFall[n]) clrLvl[lv] = 1'b1;
      if (pendM[n] && !disM[n] && !disM[GDIS_BIT] &&
          ((lv == 4'd15) || ((lv > cpuPil) && cpuTrapEn)))
        qualLvl[lv] = 1'b1;
    end
  end

  always_comb begin
    bestLvl = 4'd0;
    anyQual = 1'b0;
    for (int l = 0; l < LVL_N; l++) begin
      if (qualLvl[l]) begin
        bestLvl = 4'(l);
        anyQual = 1'b1;
      end
    end
  end

  // processor pending next state: bus first, then source edges on the target
  always_comb begin
    for (int c = 0; c < NCPU; c++) begin
      pendCNext[c] = pendC[c];
      if (strb.pendClrWr && (pageIdx == CPU_W'(c))) pendCNext[c] = pendCNext[c] & ~wdata;
      if (strb.pendSetWr && (pageIdx == CPU_W'(c))) pendCNext[c] = pendCNext[c] | wdata;
      if (tgt == CPU_W'(c)) begin
        pendCNext[c] = pendCNext[c] & ~{{(DATA_W-LVL_N){1'b0}}, clrLvl};
        pendCNext[c] = pendCNext[c] | {{(DATA_W-LVL_N){1'b0}}, setLvl};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      srcPrev  <= '0;
      pendM    <= '0;
      disM     <= '1;
      tgt      <= '0;
      reqExt   <= 1'b0;
      reqLevel <= 4'd0;
      for (int c = 0; c < NCPU; c++) pendC[c] <= '0;
    end else begin
      srcPrev  <= srcLines;
      pendM    <= ((pendM & ~disSetMask) & ~srcFall) | srcRise;
      disM     <= (disM & ~enMask) | disSetMask;
      if (strb.tgtWr) tgt <= wdata[CPU_W-1:0];
      reqExt   <= anyQual;
      reqLevel <= anyQual ? bestLvl : 4'd0;
      for (int c = 0; c < NCPU; c++) pendC[c] <= pendCNext[c];
    end
  end

  always_comb begin
    case (rdSel)
      RD_MPEND: rdata = pendM;
      RD_MDIS:  rdata = disM;
      RD_TGT:   rdata = {{(DATA_W-CPU_W){1'b0}}, tgt};
      RD_CPEND: rdata = pendC[pageIdx];
      default:  rdata = '0;
    endcase
  end

  // R3: a rising source is pending in the master word one edge later
  assert_rise_pends_R3: assert property (@(posedge clk) disable iff (rst)
    (|srcRise) |=> ((pendM & $past(srcRise)) == $past(srcRise)));

  // R4: a request is never raised while the global disable was set
  assert_gdis_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    reqExt |-> !$past(disM[GDIS_BIT]));

  // R4: below level 15 the priority and trap-enable rule held
  assert_prio_rule_R4: assert property (@(posedge clk) disable iff (rst)
    (reqExt && (reqLevel != 4'd15)) |-> ($past(cpuTrapEn) && (reqLevel > $past(cpuPil))));

  // R5: idle request carries level 0
  assert_idle_level_R5: assert property (@(posedge clk) disable iff (rst)
    !reqExt |-> (reqLevel == 4'd0));

  // R6: enabled sources read back as not disabled
  assert_enable_clears_R6: assert property (@(posedge clk) disable iff (rst)
    strb.enWr |=> ((disM & $past(wdata)) == '0));

  // R7: disable-set drops pending unless the source rose in the same cycle
  assert_disset_clears_R7: assert property (@(posedge clk) disable iff (rst)
    strb.disWr |=> ((pendM & $past(wdata) & ~$past(srcRise)) == '0));

endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lvl_irq_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       srcLines,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [3:0]        cpuPil,
  input  logic              cpuTrapEn,
  output logic              reqExt,
  output logic [3:0]        reqLevel
);

  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1;

  wrStrobe_t        strb;
  rdSel_e           rdSel;
  logic [CPU_W-1:0] pageIdx;

  lvl_irq_decode #(
    .ADDR_W(ADDR_W),
    .CPU_W(CPU_W)
  ) decode_i (
    .busAddr(busAddr),
    .busWe(busWe),
    .strb(strb),
    .rdSel(rdSel),
    .pageIdx(pageIdx)
  );

  lvl_irq_datapath #(
    .NCPU(NCPU),
    .CPU_W(CPU_W)
  ) datapath_i (
    .clk(clk),
    .rst(rst),
    .srcLines(srcLines),
    .strb(strb),
    .rdSel(rdSel),
    .pageIdx(pageIdx),
    .wdata(busWdata),
    .cpuPil(cpuPil),
    .cpuTrapEn(cpuTrapEn),
    .rdata(busRdata),
    .reqExt(reqExt),
    .reqLevel(reqLevel)
  );

endmodule

// File: tb/lvl_irq_ctrl_tb_top.sv
module lvl_irq_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCPU = 4;
  localparam int AW = 16;
  localparam int WATCHDOG = 20000;

  // R2 mapping, written independently of the design
  localparam int unsigned LVL_TAB [32] = '{
    2, 3, 5, 7, 9, 11, 0, 14, 3, 5, 7, 9, 11, 13, 12, 12,
    6, 0, 4, 10, 8, 0, 11, 0, 0, 0, 0, 0, 15, 0, 0, 0};

  // {we, addr, data, expected read, requirement number}
  localparam int NVEC = 32;
  localparam logic [88:0] VECS [NVEC] = '{
    {1'b0, 16'h8000, 32'h0000_0000, 32'h0000_0000, 8'd1},  // R1
    {1'b0, 16'h8004, 32'h0000_0000, 32'hFFFF_FFFF, 8'd1},  // R1
    {1'b0, 16'h8010, 32'h0000_0000, 32'h0000_0000, 8'd1},  // R1
    {1'b0, 16'h0000, 32'h0000_0000, 32'h0000_0000, 8'd1},  // R1
    {1'b1, 16'h8008, 32'h0000_00F0, 32'h0000_0000, 8'd6},  // R6
    {1'b0, 16'h8004, 32'h0000_0000, 32'hFFFF_FF0F, 8'd6},  // R6
    {1'b1, 16'h800C, 32'h0000_0030, 32'h0000_0000, 8'd7},  // R7
    {1'b0, 16'h8004, 32'h0000_0000, 32'hFFFF_FF3F, 8'd7},  // R7
    {1'b1, 16'h8010, 32'h0000_0007, 32'h0000_0000, 8'd8},  // R8
    {1'b0, 16'h8010, 32'h0000_0000, 32'h0000_0003, 8'd8},  // R8
    {1'b0, 16'h800C, 32'h0000_0000, 32'h0000_0000, 8'd9},  // R9
    {1'b0, 16'h8014, 32'h0000_0000, 32'h0000_0000, 8'd9},  // R9
    {1'b1, 16'h1008, 32'hA5A5_0000, 32'h0000_0000, 8'd10}, // R10
    {1'b0, 16'h1000, 32'h0000_0000, 32'hA5A5_0000, 8'd10}, // R10
    {1'b0, 16'h100C, 32'h0000_0000, 32'hA5A5_0000, 8'd10}, // R10
    {1'b1, 16'h1004, 32'h0500_0000, 32'h0000_0000, 8'd10}, // R10
    {1'b0, 16'h1000, 32'h0000_0000, 32'hA0A5_0000, 8'd10}, // R10
    {1'b1, 16'h1000, 32'hFFFF_FFFF, 32'h0000_0000, 8'd10}, // R10
    {1'b1, 16'h100C, 32'hFFFF_FFFF, 32'h0000_0000, 8'd10}, // R10
    {1'b0, 16'h1000, 32'h0000_0000, 32'hA0A5_0000, 8'd10}, // R10
    {1'b0, 16'h2000, 32'h0000_0000, 32'h0000_0000, 8'd10}, // R10
    {1'b1, 16'h800A, 32'hFFFF_FFFF, 32'h0000_0000, 8'd12}, // R12
    {1'b0, 16'h8004, 32'h0000_0000, 32'hFFFF_FF3F, 8'd12}, // R12
    {1'b1, 16'h4008, 32'h0000_00FF, 32'h0000_0000, 8'd12}, // R12
    {1'b0, 16'h0000, 32'h0000_0000, 32'h0000_0000, 8'd12}, // R12
    {1'b0, 16'h8005, 32'h0000_0000, 32'h0000_0000, 8'd12}, // R12
    {1'b1, 16'h1004, 32'hFFFF_FFFF, 32'h0000_0000, 8'd10}, // R10
    {1'b1, 16'h8010, 32'h0000_0000, 32'h0000_0000, 8'd8},  // R8
    {1'b1, 16'h8008, 32'hFFFF_FFFF, 32'h0000_0000, 8'd6},  // R6
    {1'b0, 16'h8004, 32'h0000_0000, 32'h0000_0000, 8'd6},  // R6
    {1'b0, 16'h1000, 32'h0000_0000, 32'h0000_0000, 8'd10}, // R10
    {1'b0, 16'h8010, 32'h0000_0000, 32'h0000_0000, 8'd8}   // R8
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [31:0]   srcLines = '0;
  logic [AW-1:0] busAddr = '0;
  logic          busWe = 1'b0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [3:0]    cpuPil = 4'd0;
  logic          cpuTrapEn = 1'b0;
  logic          reqExt;
  logic [3:0]    reqLevel;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  lvl_irq_ctrl #(.NCPU(NCPU), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .srcLines(srcLines),
    .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata),
    .cpuPil(cpuPil), .cpuTrapEn(cpuTrapEn),
    .reqExt(reqExt), .reqLevel(reqLevel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // call during the low phase; the write lands at the next rising edge
  task automatic busWrite(input logic [AW-1:0] a, input logic [31:0] d);
    busAddr = a;
    busWe = 1'b1;
    busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic readChk(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
    busAddr = a;
    busWe = 1'b0;
    #1;
    chk(tag, busRdata, exp);
  endtask

  task automatic reqChk(input string tag, input logic expExt, input logic [3:0] expLvl);
    chk({tag, " ext"}, {31'b0, reqExt}, {31'b0, expExt});
    chk({tag, " lvl"}, {28'b0, reqLevel}, {28'b0, expLvl});
  endtask

  task automatic idleSources();
    srcLines = '0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    reqChk("R1 reset request", 1'b0, 4'd0);

    // register vectors
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      if (VECS[i][88]) busWrite(VECS[i][87:72], VECS[i][71:40]);
      else readChk($sformatf("R%0d vec%0d", VECS[i][7:0], i), VECS[i][87:72], VECS[i][39:8]);
    end

    // R2 R3 R5: every source alone, target 0, all enabled
    cpuPil = 4'd0;
    cpuTrapEn = 1'b1;
    for (int n = 0; n < 32; n++) begin
      @(negedge clk);
      srcLines = 32'h1 << n;
      @(negedge clk);
      readChk($sformatf("R3 master pend src%0d", n), 16'h8000, 32'h1 << n);
      readChk($sformatf("R2 cpu0 level src%0d", n), 16'h0000, 32'h1 << LVL_TAB[n]);
      @(negedge clk);
      reqChk($sformatf("R5 request src%0d", n), (LVL_TAB[n] != 0), 4'(LVL_TAB[n]));
      srcLines = '0;
      @(negedge clk);
      readChk($sformatf("R3 master clear src%0d", n), 16'h8000, 32'h0);
      readChk($sformatf("R3 cpu0 clear src%0d", n), 16'h0000, 32'h0);
      @(negedge clk);
      reqChk($sformatf("R5 drop src%0d", n), 1'b0, 4'd0);
    end

    // R4: priority, trap-enable, level 15 bypass, global and per-source disable
    cpuPil = 4'd10;
    cpuTrapEn = 1'b1;
    srcLines[19] = 1'b1;                    // level 10
    repeat (2) @(negedge clk);
    reqChk("R4 level equal to pil", 1'b0, 4'd0);
    srcLines[7] = 1'b1;                     // level 14
    repeat (2) @(negedge clk);
    reqChk("R4 level above pil", 1'b1, 4'd14);
    cpuTrapEn = 1'b0;
    @(negedge clk);
    reqChk("R4 trap disabled", 1'b0, 4'd0);
    srcLines[28] = 1'b1;                    // level 15
    repeat (2) @(negedge clk);
    reqChk("R4 level 15 bypass", 1'b1, 4'd15);
    busWrite(16'h800C, 32'h8000_0000);
    @(negedge clk);
    reqChk("R4 global disable", 1'b0, 4'd0);
    busWrite(16'h8008, 32'h8000_0000);
    @(negedge clk);
    reqChk("R4 global enable", 1'b1, 4'd15);
    busWrite(16'h800C, 32'h1000_0000);
    readChk("R7 disable drops pending", 16'h8000, 32'h0008_0080);
    @(negedge clk);
    reqChk("R4 source disabled", 1'b0, 4'd0);
    cpuTrapEn = 1'b1;
    @(negedge clk);
    reqChk("R4 trap enabled again", 1'b1, 4'd14);
    cpuPil = 4'd14;
    @(negedge clk);
    reqChk("R4 pil equals level", 1'b0, 4'd0);
    cpuPil = 4'd13;
    @(negedge clk);
    reqChk("R4 pil below level", 1'b1, 4'd14);
    idleSources();
    busWrite(16'h8008, 32'h1000_0000);

    // R5: highest of several levels
    cpuPil = 4'd0;
    cpuTrapEn = 1'b1;
    srcLines = (32'h1 << 0) | (32'h1 << 2) | (32'h1 << 13);
    repeat (2) @(negedge clk);
    reqChk("R5 highest of three", 1'b1, 4'd13);
    srcLines[13] = 1'b0;
    repeat (2) @(negedge clk);
    reqChk("R5 next highest", 1'b1, 4'd5);
    idleSources();

    // R8: target change redirects level bits
    busWrite(16'h8010, 32'h0000_0006);
    readChk("R8 target masked", 16'h8010, 32'h2);
    srcLines[1] = 1'b1;                     // level 3
    @(negedge clk);
    readChk("R8 new target pending", 16'h2000, 32'h0000_0008);
    readChk("R8 old target untouched", 16'h0000, 32'h0);
    srcLines = '0;
    @(negedge clk);
    readChk("R8 new target cleared", 16'h2000, 32'h0);
    busWrite(16'h8010, 32'h0);
    idleSources();

    // R11: source edge and bus write on the same bit in one cycle
    @(negedge clk);
    srcLines[4] = 1'b1;                     // level 9
    busWrite(16'h800C, 32'h0000_0010);
    readChk("R11 master pending kept", 16'h8000, 32'h0000_0010);
    readChk("R11 disable set", 16'h8004, 32'h0000_0010);
    @(negedge clk);
    reqChk("R11 disabled no request", 1'b0, 4'd0);
    srcLines[4] = 1'b0;
    @(negedge clk);
    srcLines[5] = 1'b1;                     // level 11
    busWrite(16'h0004, 32'h0000_0800);
    readChk("R11 cpu pending kept", 16'h0000, 32'h0000_0800);
    idleSources();
    busWrite(16'h8008, 32'h0000_0010);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule